// File: doc/BRIEF.md
# Decimating Boxcar Sample Smoother

This block sits between a sensor sample source and a slow consumer such as a numeric display. Samples are 8 bits wide and arrive with a valid strobe one clock long, typically at about 62.5 k samples per second (one sample per 16 serial clocks of a 1 MHz converter link). A fast, noisy stream like that makes a readout flicker, so the block thins it out and smooths it before passing it on.

A counter of accepted samples keeps one sample in every N, where N comes from a programmable input. Each kept sample enters a short history window of TAPS entries. The equal-weight average of that window is taken: a right shift when TAPS is a power of two, and a constant divide otherwise. A selectable number of low result bits can then be cleared. The smoothed value leaves on its own one-clock valid strobe. The input side never stalls.

Top module: `sample_smoother`

## Requirements
- R1: `in_ready` is 1 in every cycle out of reset.
- R2: While `rst_n` is low and right after it, `out_valid` is 0 and `out_data` is 0. The tap history starts at zero.
- R3: A sample is accepted only in a cycle with `in_valid` high. With `decim_n` = N ≥ 2, the N-th, 2N-th, ... accepted samples are kept and the rest are dropped. A `decim_n` of 0 or 1 keeps every sample. If `decim_n` drops below the running count, the next accepted sample is kept.
- R4: `out_valid` is high for exactly the one clock after a kept sample that completes a full window, and it is low in every other cycle.
- R5: No `out_valid` is raised until TAPS samples have been kept since reset.
- R6: For a TAPS that is not a power of two (default 3), `out_data` is the sum of the last TAPS kept samples divided by TAPS, rounded toward zero. The sum is held at 8 + ceil(log2 TAPS) bits, so it never overflows.
- R7: For a power-of-two TAPS (for example 4), `out_data` is the window sum shifted right by log2 TAPS. This is the same floor result.
- R8: With `mask_bits` = k (0..7) in the cycle the completing sample is kept, the low k bits of that output are 0 and the upper bits equal the average.
- R9: `out_data` holds its value in every cycle where `out_valid` is low.
- R10: Data presented while `in_valid` is low has no effect on the count, the history or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-clock strobe marking a new input sample |
| in_data | input | 8 | Input sample |
| in_ready | output | 1 | Always 1: a sample is taken in any cycle |
| decim_n | input | 8 | Keep one of every N accepted samples (0 and 1 keep all) |
| mask_bits | input | 3 | Number of low result bits forced to zero |
| out_valid | output | 1 | One-clock strobe for a new smoothed value |
| out_data | output | 8 | Smoothed, masked value |

## Verification
The hardest situation to reach from the ports is a change of the decimation ratio that lands while the counter of dropped samples already stands above the new limit, combined with a window that is only partly filled. Only this case shows whether the block keeps the next sample or wraps around. The stimulus reaches it by drawing a fresh ratio from a small range every few samples in the random phase, so a reduction in mid-group happens many times. Directed runs of all-ones samples under the widest mask, and a reset-to-first-window phase, cover the sum ceiling and the fill rule.

// File: rtl/sample_smoother.sv
module sample_smoother #(
  parameter int DW   = 8,
  parameter int TAPS = 3,
  parameter int CW   = 8,
  parameter int MW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic [CW-1:0] decim_n,
  input  logic [MW-1:0] mask_bits,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int AW   = DW + $clog2(TAPS);
  localparam int FW   = $clog2(TAPS + 1);
  localparam int SH   = $clog2(TAPS);
  localparam bit POW2 = (TAPS & (TAPS - 1)) == 0;

  logic [CW-1:0] cnt;
  logic [FW-1:0] fill;
  logic [DW-1:0] hist [TAPS-1];
  logic          keep, full_next;
  logic [AW-1:0] sum, quo;
  logic [DW-1:0] lowm;

  assign in_ready  = 1'b1;
  assign keep      = in_valid && (decim_n <= CW'(1) || cnt >= decim_n - CW'(1));
  assign full_next = fill >= FW'(TAPS - 1);
  assign lowm      = (DW'(1) << mask_bits) - DW'(1);

  always_comb begin
    sum = AW'(in_data);
    for (int i = 0; i < TAPS - 1; i++) sum = sum + AW'(hist[i]);
  end

  generate
    if (POW2) begin : g_shift
      assign quo = sum >> SH;
    end else begin : g_div
      assign quo = sum / AW'(TAPS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < TAPS - 1; i++) hist[i] <= '0;
    end else begin
      out_valid <= keep && full_next;
      if (in_valid) cnt <= keep ? '0 : cnt + CW'(1);
      if (keep) begin
        hist[0] <= in_data;
        for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
        if (!full_next) fill <= fill + FW'(1);
        else begin
          fill     <= FW'(TAPS);
          out_data <= quo[DW-1:0] & ~lowm;
        end
      end
    end
  end
endmodule

module smoother_chk #(
  parameter int DW   = 8,
  parameter int TAPS = 3,
  parameter int MW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [MW-1:0] mask_bits,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  logic [7:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen < 8'(TAPS)) seen <= seen + 8'd1;
  end

  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  p_valid_after_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_no_early_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen >= 8'(TAPS));
  p_low_bits_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ((DW'(1) << $past(mask_bits)) - DW'(1))) == '0));
  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind sample_smoother smoother_chk #(.DW(DW), .TAPS(TAPS), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mask_bits(mask_bits), .out_valid(out_valid), .out_data(out_data));

// File: tb/tb_sample_smoother.sv
module tb_sample_smoother;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [7:0] decim_n = '0;
  logic [2:0] mask_bits = '0;
  logic       rdy3, rdy4, ov3, ov4;
  logic [7:0] od3, od4;

  always #5 clk = ~clk;

  sample_smoother #(.TAPS(3)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(rdy3),
    .decim_n(decim_n), .mask_bits(mask_bits), .out_valid(ov3), .out_data(od3));

  sample_smoother #(.TAPS(4)) dut_p2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(rdy4),
    .decim_n(decim_n), .mask_bits(mask_bits), .out_valid(ov4), .out_data(od4));

  int checks = 0, fails = 0, cyc = 0, cnt = 0, f3 = 0, f4 = 0;
  logic [7:0] h3 [3], h4 [4];
  logic [7:0] e3_d = '0, e4_d = '0;
  bit e3_v = 0, e4_v = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  task automatic model(input logic [7:0] d);
    bit keep;
    int s3, s4;
    logic [7:0] lm;
    keep = (decim_n <= 1) || (cnt >= int'(decim_n) - 1);
    cnt = keep ? 0 : cnt + 1;
    e3_v = 0; e4_v = 0;
    if (keep) begin
      lm = 8'((1 << mask_bits) - 1);
      h3[2] = h3[1]; h3[1] = h3[0]; h3[0] = d;
      h4[3] = h4[2]; h4[2] = h4[1]; h4[1] = h4[0]; h4[0] = d;
      if (f3 < 3) f3++;
      if (f4 < 4) f4++;
      s3 = h3[0] + h3[1] + h3[2];
      s4 = h4[0] + h4[1] + h4[2] + h4[3];
      if (f3 == 3) begin e3_v = 1; e3_d = 8'(s3 / 3) & ~lm; end
      if (f4 == 4) begin e4_v = 1; e4_d = 8'(s4 / 4) & ~lm; end
    end
  endtask

  task automatic send(input logic [7:0] d, input int gap);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    model(d);
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'($urandom);
    chk(ov3 == e3_v, (f3 < 3) ? "R5" : "R3/R4", ov3, e3_v);
    chk(ov4 == e4_v, (f4 < 4) ? "R5" : "R3/R4", ov4, e4_v);
    chk(od3 == e3_d, (mask_bits != 0) ? "R8" : "R6", od3, e3_d);
    chk(od4 == e4_d, (mask_bits != 0) ? "R8" : "R7", od4, e4_d);
    chk(rdy3 && rdy4, "R1", rdy3 & rdy4, 1);
    for (int g = 0; g < gap; g++) begin
      in_data = 8'($urandom);
      @(negedge clk);
      chk(!ov3 && !ov4, "R10", ov3 | ov4, 0);
      chk(od3 == e3_d && od4 == e4_d, "R9", od3, e3_d);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) h3[i] = '0;
    for (int i = 0; i < 4; i++) h4[i] = '0;
    repeat (3) @(negedge clk);
    chk(!ov3 && !ov4 && od3 == 0 && od4 == 0, "R2", od3, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ov3 && !ov4 && od3 == 0, "R2", ov3, 0);

    // R3 and R5: keep every third sample, window fills from reset
    decim_n = 8'd3;
    for (int i = 1; i <= 15; i++) send(8'(i * 10), 1);

    // R6/R7 ceiling, then R8 widest mask
    decim_n = 8'd0;
    for (int i = 0; i < 5; i++) send(8'hFF, 0);
    mask_bits = 3'd7;
    for (int i = 0; i < 2; i++) send(8'hFF, 2);
    mask_bits = 3'd0;
    decim_n = 8'd1;
    send(8'd1, 0); send(8'd2, 0); send(8'd0, 1); send(8'd0, 3);

    // random phase, ratio changes mid-group
    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 5 == 0) decim_n = 8'($urandom % 6);
      if ($urandom % 4 == 0) mask_bits = 3'($urandom);
      send(8'($urandom), int'($urandom % 4));
    end
    done = 1;
    summary();
  end
endmodule